// File: doc/BRIEF.md
# SDRAM command timing guard

This block sits between an SDRAM command scheduler and the memory command bus. Each clock the scheduler presents one candidate command (opcode, bank, auto-precharge flag). The guard answers with a combinational `allow` for that same clock. The scheduler then raises `req_issue` to commit the command. An allowed issue updates the per-bank and bus-wide timing state. A refused issue changes nothing and raises an error pulse one clock later.

All minimum delays are parameters in picoseconds, next to the clock period. At elaboration each one becomes a whole number of clocks by dividing by the period and rounding up. Four banks each keep their own open/closed state, down-counters and an open-age counter. One shared counter spaces ACTIVE commands across banks. The guard also flags a bank that has stayed open close to the maximum row-open time. When a read burst is cut short by a burst stop or a precharge, it reports how many read beats still arrive.

Top module: `sdram_cmd_guard`

## Requirements
- R1: Each delay converts to clocks as ceil(delay / period). At the default 8 ns clock the values are: ACTIVE spacing across banks 2, ACTIVE to column 3, PRECHARGE to ACTIVE 3, ACTIVE to PRECHARGE 6, ACTIVE to ACTIVE in one bank 9.
- R2: ACTIVE (opcode 1) is allowed only to a closed bank, and only when all three spacings are met: the cross-bank spacing since any ACTIVE, the same-bank spacing since that bank's ACTIVE, and the precharge time since that bank closed.
- R3: READ (opcode 2) and WRITE (opcode 3) are allowed only to an open bank, at least the ACTIVE-to-column delay after its ACTIVE. Column commands may follow one another on consecutive clocks.
- R4: PRECHARGE (opcode 4) is allowed only to an open bank. It needs the ACTIVE-to-PRECHARGE time since its ACTIVE, and BURST_LEN-1+TWR clocks since its last WRITE issue. TWR is 2, or 1 when the period exceeds 10 ns and MANUAL_PRE_ONLY is 1.
- R5: A READ or WRITE with `req_ap`=1 closes its bank. The next ACTIVE to that bank then waits BURST_LEN-1+TWR+precharge clocks after an auto-precharge WRITE, or BURST_LEN+precharge clocks after an auto-precharge READ.
- R6: NOP (opcode 0) and BURST STOP (opcode 5) are always allowed. Opcodes 6 and 7 are never allowed.
- R7: An issue while `allow` is low raises `err` for exactly the next clock and leaves all state unchanged. `err` is low after every other clock.
- R8: A BURST STOP, or a PRECHARGE to the bank being read, issued 1 to BURST_LEN-1 clocks after a READ, raises `intr_valid` on the next clock. At the same time `intr_beats` shows CAS_LAT-1 (2, 1 or 0). A WRITE ends the tracked read burst.
- R9: `pre_due[b]` is high while bank b has been open for at least ceil(T_RAS_MAX/period) - DUE_MARGIN clocks (12436 at defaults). It falls when the bank closes.
- R10: After reset all banks are closed, and `err`, `intr_valid` and `pre_due` are low. ACTIVE to any bank is allowed on the first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_op | input | 3 | Candidate opcode: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 BURST STOP |
| req_bank | input | BANK_W | Target bank |
| req_ap | input | 1 | Auto-precharge flag for READ/WRITE |
| req_issue | input | 1 | Scheduler commits the candidate this clock |
| allow | output | 1 | Candidate is legal this clock |
| err | output | 1 | Previous clock issued a refused command |
| pre_due | output | NUM_BANKS | Bank is near its maximum open time |
| intr_valid | output | 1 | Previous clock interrupted a read burst |
| intr_beats | output | 2 | Read beats still delivered after that interrupt |

## Verification
The assertions take for granted that `req_op`, `req_bank`, `req_ap` and `req_issue` are known values on every clock after reset. They also assume the opcode and bank presented with `req_issue` are the ones that `allow` answered in that same clock. The stimulus drives every request field once per clock, half a period away from the active edge. Random streams mix legal and illegal opcodes, issue and hold. Each decision is predicted by a reference model that records the clock index of every committed command.

// File: rtl/sdg_pkg.sv
`timescale 1ns/1ps
package sdg_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_BST = 3'd5
  } sdg_op_e;

  // R1: minimum delay in ps to whole clocks, rounded up, never below 1
  function automatic int ps_to_clk(input int t_ps, input int clk_ps);
    longint c;
    c = (longint'(t_ps) + longint'(clk_ps) - 1) / longint'(clk_ps);
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  // R4: one-clock write recovery only for slow clocks with manual precharge
  function automatic int wr_recovery(input int clk_ps, input int manual_only);
    return (clk_ps > 10000 && manual_only != 0) ? 1 : 2;
  endfunction

  // R8: read beats still delivered after an interrupt
  function automatic int trail_beats(input int cas);
    return (cas > 1) ? cas - 1 : 0;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int width_for(input int v);
    return (v < 1) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/sdg_bank_timer.sv
`timescale 1ns/1ps
module sdg_bank_timer
  import sdg_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int AGE_W     = 14,
  parameter int RCD_N     = 3,
  parameter int RAS_N     = 6,
  parameter int RC_N      = 9,
  parameter int RP_N      = 3,
  parameter int WRPRE_N   = 5,
  parameter int WRAP_N    = 8,
  parameter int RDAP_N    = 7,
  parameter int AGE_LIMIT = 12436
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic ap_i,
  input  logic pre_i,
  output logic open_o,
  output logic act_ok_o,
  output logic col_ok_o,
  output logic pre_ok_o,
  output logic due_o
);

  // counters hold N-1 so that the command becomes legal exactly N clocks later
  localparam logic [CNT_W-1:0] RCD_LD   = CNT_W'(RCD_N - 1);
  localparam logic [CNT_W-1:0] RAS_LD   = CNT_W'(RAS_N - 1);
  localparam logic [CNT_W-1:0] RC_LD    = CNT_W'(RC_N - 1);
  localparam logic [CNT_W-1:0] RP_LD    = CNT_W'(RP_N - 1);
  localparam logic [CNT_W-1:0] WRPRE_LD = CNT_W'(WRPRE_N - 1);
  localparam logic [CNT_W-1:0] WRAP_LD  = CNT_W'(WRAP_N - 1);
  localparam logic [CNT_W-1:0] RDAP_LD  = CNT_W'(RDAP_N - 1);
  localparam logic [AGE_W-1:0] AGE_TOP  = AGE_W'(AGE_LIMIT);

  logic             open_q;
  logic [CNT_W-1:0] rcd_q, ras_q, rc_q, rp_q, wrr_q;
  logic [AGE_W-1:0] age_q;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rcd_q  <= '0;
      ras_q  <= '0;
      rc_q   <= '0;
      rp_q   <= '0;
      wrr_q  <= '0;
      age_q  <= '0;
    end else begin
      rcd_q <= step_down(rcd_q);
      ras_q <= step_down(ras_q);
      rc_q  <= step_down(rc_q);
      rp_q  <= step_down(rp_q);
      wrr_q <= step_down(wrr_q);
      if (open_q && age_q < AGE_TOP) age_q <= age_q + 1'b1;
      if (act_i) begin
        open_q <= 1'b1;
        rcd_q  <= RCD_LD;
        ras_q  <= RAS_LD;
        rc_q   <= RC_LD;
        age_q  <= AGE_W'(1);
      end
      if (rd_i && ap_i) begin
        open_q <= 1'b0;
        rp_q   <= RDAP_LD;
        age_q  <= '0;
      end
      if (wr_i) begin
        wrr_q <= WRPRE_LD;
        if (ap_i) begin
          open_q <= 1'b0;
          rp_q   <= WRAP_LD;
          age_q  <= '0;
        end
      end
      if (pre_i) begin
        open_q <= 1'b0;
        rp_q   <= RP_LD;
        age_q  <= '0;
      end
    end
  end

  assign open_o   = open_q;
  assign act_ok_o = !open_q && rc_q == '0 && rp_q == '0;
  assign col_ok_o = open_q && rcd_q == '0;
  assign pre_ok_o = open_q && ras_q == '0 && wrr_q == '0;
  assign due_o    = open_q && age_q >= AGE_TOP;

endmodule

// File: rtl/sdg_bus_timer.sv
`timescale 1ns/1ps
module sdg_bus_timer
  import sdg_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int BANK_W    = 2,
  parameter int RRD_N     = 2,
  parameter int BURST_LEN = 4,
  parameter int TRAIL     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              bst_i,
  input  logic              pre_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              rrd_ok_o,
  output logic              intr_hit_o,
  output logic              intr_valid_o,
  output logic [1:0]        intr_beats_o
);

  localparam int               BL_W   = width_for(BURST_LEN);
  localparam logic [CNT_W-1:0] RRD_LD = CNT_W'(RRD_N - 1);
  localparam logic [BL_W-1:0]  BL_LD  = BL_W'(BURST_LEN - 1);

  logic [CNT_W-1:0]  rrd_q;
  logic [BL_W-1:0]   rd_left_q;
  logic [BANK_W-1:0] rd_bank_q;
  logic              intr_q;

  // R8: a burst is in flight while later beats of the last READ remain
  assign intr_hit_o = (rd_left_q != '0) &&
                      (bst_i || (pre_i && bank_i == rd_bank_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_q     <= '0;
      rd_left_q <= '0;
      rd_bank_q <= '0;
      intr_q    <= 1'b0;
    end else begin
      rrd_q     <= (rrd_q == '0) ? rrd_q : rrd_q - 1'b1;
      rd_left_q <= (rd_left_q == '0) ? rd_left_q : rd_left_q - 1'b1;
      intr_q    <= intr_hit_o;
      if (act_i) rrd_q <= RRD_LD;
      if (rd_i) begin
        rd_left_q <= BL_LD;
        rd_bank_q <= bank_i;
      end
      if (wr_i || intr_hit_o) rd_left_q <= '0;
    end
  end

  assign rrd_ok_o     = (rrd_q == '0);
  assign intr_valid_o = intr_q;
  assign intr_beats_o = intr_q ? 2'(TRAIL) : 2'd0;

endmodule

// File: rtl/sdg_legality.sv
`timescale 1ns/1ps
module sdg_legality
  import sdg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic [2:0]           op_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [NUM_BANKS-1:0] act_ok_i,
  input  logic [NUM_BANKS-1:0] col_ok_i,
  input  logic [NUM_BANKS-1:0] pre_ok_i,
  input  logic                 rrd_ok_i,
  output logic                 allow_o
);

  always_comb begin
    case (op_i)
      OP_NOP, OP_BST: allow_o = 1'b1;
      OP_ACT:         allow_o = act_ok_i[bank_i] && rrd_ok_i;
      OP_RD, OP_WR:   allow_o = col_ok_i[bank_i];
      OP_PRE:         allow_o = pre_ok_i[bank_i];
      default:        allow_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/sdram_cmd_guard.sv
`timescale 1ns/1ps
module sdram_cmd_guard
  import sdg_pkg::*;
#(
  parameter int NUM_BANKS       = 4,
  parameter int BANK_W          = $clog2(NUM_BANKS),
  parameter int CLK_PS          = 8000,
  parameter int T_RRD_PS        = 16000,
  parameter int T_RCD_PS        = 19000,
  parameter int T_RP_PS         = 19000,
  parameter int T_RAS_PS        = 48000,
  parameter int T_RC_PS         = 68000,
  parameter int T_RAS_MAX_PS    = 100_000_000,
  parameter int DUE_MARGIN      = 64,
  parameter int BURST_LEN       = 4,
  parameter int CAS_LAT         = 3,
  parameter int MANUAL_PRE_ONLY = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           req_op,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic                 req_ap,
  input  logic                 req_issue,
  output logic                 allow,
  output logic                 err,
  output logic [NUM_BANKS-1:0] pre_due,
  output logic                 intr_valid,
  output logic [1:0]           intr_beats
);

  // R1: elaboration-time conversion to clocks
  localparam int RRD_CYC   = ps_to_clk(T_RRD_PS, CLK_PS);
  localparam int RCD_CYC   = ps_to_clk(T_RCD_PS, CLK_PS);
  localparam int RP_CYC    = ps_to_clk(T_RP_PS, CLK_PS);
  localparam int RAS_CYC   = ps_to_clk(T_RAS_PS, CLK_PS);
  localparam int RC_CYC    = ps_to_clk(T_RC_PS, CLK_PS);
  localparam int TWR_CYC   = wr_recovery(CLK_PS, MANUAL_PRE_ONLY);
  localparam int WRPRE_CYC = BURST_LEN - 1 + TWR_CYC;
  localparam int WRAP_CYC  = WRPRE_CYC + RP_CYC;
  localparam int RDAP_CYC  = BURST_LEN + RP_CYC;
  localparam int AGE_LIMIT = ps_to_clk(T_RAS_MAX_PS, CLK_PS) - DUE_MARGIN;
  localparam int TRAIL     = trail_beats(CAS_LAT);
  localparam int CNT_MAX   = max_of(max_of(max_of(RC_CYC, RAS_CYC), max_of(WRAP_CYC, RDAP_CYC)),
                                    max_of(max_of(RRD_CYC, RCD_CYC), BURST_LEN));
  localparam int CNT_W     = width_for(CNT_MAX);
  localparam int AGE_W     = width_for(AGE_LIMIT);

  logic                 fire_w;
  logic                 is_act, is_rd, is_wr, is_pre, is_bst;
  logic [NUM_BANKS-1:0] bank_open_w, act_ok_w, col_ok_w, pre_ok_w;
  logic                 rrd_ok_w, intr_hit_w, err_q;

  assign fire_w = req_issue && allow;
  assign is_act = fire_w && req_op == OP_ACT;
  assign is_rd  = fire_w && req_op == OP_RD;
  assign is_wr  = fire_w && req_op == OP_WR;
  assign is_pre = fire_w && req_op == OP_PRE;
  assign is_bst = fire_w && req_op == OP_BST;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (req_bank == BANK_W'(b));
    sdg_bank_timer #(
      .CNT_W(CNT_W), .AGE_W(AGE_W), .RCD_N(RCD_CYC), .RAS_N(RAS_CYC),
      .RC_N(RC_CYC), .RP_N(RP_CYC), .WRPRE_N(WRPRE_CYC), .WRAP_N(WRAP_CYC),
      .RDAP_N(RDAP_CYC), .AGE_LIMIT(AGE_LIMIT)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_i    (is_act && sel),
      .rd_i     (is_rd && sel),
      .wr_i     (is_wr && sel),
      .ap_i     (req_ap),
      .pre_i    (is_pre && sel),
      .open_o   (bank_open_w[b]),
      .act_ok_o (act_ok_w[b]),
      .col_ok_o (col_ok_w[b]),
      .pre_ok_o (pre_ok_w[b]),
      .due_o    (pre_due[b])
    );
  end

  sdg_bus_timer #(
    .CNT_W(CNT_W), .BANK_W(BANK_W), .RRD_N(RRD_CYC),
    .BURST_LEN(BURST_LEN), .TRAIL(TRAIL)
  ) u_bus (
    .clk          (clk),
    .rst_n        (rst_n),
    .act_i        (is_act),
    .rd_i         (is_rd),
    .wr_i         (is_wr),
    .bst_i        (is_bst),
    .pre_i        (is_pre),
    .bank_i       (req_bank),
    .rrd_ok_o     (rrd_ok_w),
    .intr_hit_o   (intr_hit_w),
    .intr_valid_o (intr_valid),
    .intr_beats_o (intr_beats)
  );

  sdg_legality #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_legal (
    .op_i     (req_op),
    .bank_i   (req_bank),
    .act_ok_i (act_ok_w),
    .col_ok_i (col_ok_w),
    .pre_ok_i (pre_ok_w),
    .rrd_ok_i (rrd_ok_w),
    .allow_o  (allow)
  );

  // R7: refused issue reported one clock later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= req_issue && !allow;
  end
  assign err = err_q;

endmodule

// File: rtl/sdram_cmd_guard_chk.sv
`timescale 1ns/1ps
module sdram_cmd_guard_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int RRD_CYC   = 2,
  parameter int TRAIL     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           req_op,
  input logic [BANK_W-1:0]    req_bank,
  input logic                 req_issue,
  input logic                 allow,
  input logic                 err,
  input logic [NUM_BANKS-1:0] pre_due,
  input logic                 intr_valid,
  input logic [1:0]           intr_beats,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic                 fire
);

  logic [BANK_W-1:0] bank_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= req_bank;
  end

  AST_ERR_ON_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_issue && !allow) |=> err); // R7
  AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_issue && !allow) |=> !err); // R7
  AST_REFUSAL_KEEPS_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_issue && !allow) |=> $stable(bank_open)); // R7
  AST_ACT_TO_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_op == 3'd1) |-> !bank_open[req_bank]); // R2
  AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_op == 3'd1) |=> bank_open[bank_q]); // R2
  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (RRD_CYC > 1 && fire && req_op == 3'd1) |=> !(fire && req_op == 3'd1)); // R2
  AST_PRE_CLOSES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_op == 3'd4) |=> !bank_open[bank_q]); // R4
  AST_RESERVED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op[2:1] == 2'b11) |-> !allow); // R6
  AST_TRAIL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    intr_valid |-> intr_beats == 2'(TRAIL)); // R8
  AST_DUE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_due & ~bank_open) == '0); // R9

endmodule

bind sdram_cmd_guard sdram_cmd_guard_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .RRD_CYC(RRD_CYC), .TRAIL(TRAIL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_bank(req_bank),
  .req_issue(req_issue), .allow(allow), .err(err), .pre_due(pre_due),
  .intr_valid(intr_valid), .intr_beats(intr_beats),
  .bank_open(bank_open_w), .fire(fire_w)
);

// File: tb/sdram_cmd_guard_bench.sv
`timescale 1ns/1ps
module sdram_cmd_guard_bench;

  localparam int PER_PS = 8000;
  localparam int BL     = 4;
  localparam int CAS    = 3;
  localparam int MARGIN = 64;

  function automatic int clocks(input int t_ps);
    int c;
    c = int'($ceil(real'(t_ps) / real'(PER_PS)));
    return (c < 1) ? 1 : c;
  endfunction

  // R1: expected clock counts restated from the delays
  localparam int RRD   = clocks(16000);
  localparam int RCD   = clocks(19000);
  localparam int RP    = clocks(19000);
  localparam int RAS   = clocks(48000);
  localparam int RC    = clocks(68000);
  localparam int TWR   = 2;
  localparam int LIMIT = clocks(100_000_000) - MARGIN;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [1:0] req_bank = 2'd0;
  logic       req_ap = 1'b0;
  logic       req_issue = 1'b0;
  logic       allow, err, intr_valid;
  logic [3:0] pre_due;
  logic [1:0] intr_beats;

  sdram_cmd_guard #(.CLK_PS(PER_PS), .BURST_LEN(BL), .CAS_LAT(CAS), .DUE_MARGIN(MARGIN))
  u_sdram_cmd_guard (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_bank(req_bank), .req_ap(req_ap),
    .req_issue(req_issue), .allow(allow), .err(err), .pre_due(pre_due),
    .intr_valid(intr_valid), .intr_beats(intr_beats)
  );

  always #4 clk = ~clk;

  int     n_checks = 0;
  int     n_fails  = 0;
  bit     finished = 0;
  longint n = 0;
  longint m_tact[4], m_act_ready[4], m_pre_ready[4];
  longint m_last_act, m_rd_slot;
  int     m_rd_bank;
  bit     m_open[4];
  bit     exp_err, exp_intr, last_allow;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s slot %0d: got %0d, expected %0d", tag, n, act, exp);
    end
  endtask

  function automatic bit model_allow(input logic [2:0] op, input int b);
    case (op)
      3'd0, 3'd5: return 1'b1;
      3'd1: return !m_open[b] && (n - m_last_act >= RRD) && (n - m_tact[b] >= RC) &&
                   (n >= m_act_ready[b]);
      3'd2, 3'd3: return m_open[b] && (n - m_tact[b] >= RCD);
      3'd4: return m_open[b] && (n - m_tact[b] >= RAS) && (n >= m_pre_ready[b]);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op, input bit ap);
    if (ap && (op == 3'd2 || op == 3'd3)) return "R5";
    case (op)
      3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic slot(input logic [2:0] op, input int b, input bit ap, input bit iss);
    bit ma, hit;
    @(negedge clk);
    req_op = op; req_bank = 2'(b); req_ap = ap; req_issue = iss;
    #1;
    check(err == exp_err, "R7 err", int'(err), int'(exp_err));
    check(intr_valid == exp_intr, "R8 intr_valid", int'(intr_valid), int'(exp_intr));
    if (exp_intr) check(intr_beats == 2'(CAS - 1), "R8 intr_beats", int'(intr_beats), CAS - 1);
    for (int k = 0; k < 4; k++) begin
      bit due;
      due = m_open[k] && (n - m_tact[k] >= LIMIT);
      check(pre_due[k] == due, "R9 pre_due", int'(pre_due[k]), int'(due));
    end
    ma = model_allow(op, b);
    check(allow == ma, tag_of(op, ap), int'(allow), int'(ma));
    last_allow = ma;
    exp_err = iss && !ma;
    hit = iss && ma && (n - m_rd_slot >= 1) && (n - m_rd_slot <= BL - 1) &&
          (op == 3'd5 || (op == 3'd4 && b == m_rd_bank));
    exp_intr = hit;
    if (hit) m_rd_slot = -1000;
    if (iss && ma) begin
      case (op)
        3'd1: begin m_open[b] = 1; m_tact[b] = n; m_last_act = n; end
        3'd2: begin
          m_rd_slot = n; m_rd_bank = b;
          if (ap) begin m_open[b] = 0; m_act_ready[b] = n + BL + RP; end
        end
        3'd3: begin
          m_pre_ready[b] = n + BL - 1 + TWR; m_rd_slot = -1000;
          if (ap) begin m_open[b] = 0; m_act_ready[b] = n + BL - 1 + TWR + RP; end
        end
        3'd4: begin m_open[b] = 0; m_act_ready[b] = n + RP; end
        default: ;
      endcase
    end
    n++;
  endtask

  task automatic retry(input logic [2:0] op, input int b, input bit ap);
    for (int i = 0; i < 40; i++) begin
      slot(op, b, ap, 1'b1);
      if (last_allow) break;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_checks++; n_fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < 4; k++) begin
      m_tact[k] = -1000; m_act_ready[k] = -1000; m_pre_ready[k] = -1000; m_open[k] = 0;
    end
    m_last_act = -1000; m_rd_slot = -1000; m_rd_bank = 0;
    exp_err = 0; exp_intr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state seen at the ports
    req_op = 3'd1; #1;
    check(err == 1'b0 && intr_valid == 1'b0, "R10 flags", int'(err | intr_valid), 0);
    check(pre_due == 4'd0, "R10 pre_due", int'(pre_due), 0);
    for (int b = 0; b < 4; b++) begin
      req_bank = 2'(b); #1;
      check(allow == 1'b1, "R10 act allowed", int'(allow), 1);
    end
    // R1/R2: cross-bank ACTIVE spacing, then same-bank reopen spacing
    slot(3'd1, 0, 0, 1);
    retry(3'd1, 1, 0);
    // R3: column delay, then back-to-back reads
    retry(3'd2, 0, 0);
    slot(3'd2, 0, 0, 1);
    slot(3'd2, 1, 0, 1);
    // R8: burst stop inside the burst, then one with no burst
    slot(3'd5, 0, 0, 1);
    slot(3'd0, 0, 0, 1);
    slot(3'd5, 0, 0, 1);
    // R8: precharge interrupting a read of the same bank
    slot(3'd2, 1, 0, 1);
    retry(3'd4, 1, 0);
    // R4: write recovery before precharge
    slot(3'd3, 0, 0, 1);
    retry(3'd4, 0, 0);
    // R2/R5: reopen, auto-precharge write, then ACTIVE waits
    retry(3'd1, 0, 0);
    retry(3'd3, 0, 1);
    retry(3'd1, 0, 0);
    // R5: auto-precharge read
    retry(3'd1, 2, 0);
    retry(3'd2, 2, 1);
    retry(3'd1, 2, 0);
    // R6: reserved opcodes and idle commands
    slot(3'd6, 1, 0, 1);
    slot(3'd7, 3, 0, 1);
    slot(3'd0, 2, 1, 1);
    // R7: refused PRECHARGE to a closed bank
    slot(3'd4, 3, 0, 1);
    // random mixed stream
    for (int i = 0; i < 5000; i++) begin
      slot(3'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) != 0));
    end
    // R9: close everything, hold bank 3 open past the limit, then close it
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 4 && m_open[b]; i++) retry(3'd4, b, 0);
    end
    retry(3'd1, 3, 0);
    for (int i = 0; i < LIMIT + 8; i++) slot(3'd0, 0, 0, 0);
    check(pre_due[3] == 1'b1, "R9 flag raised", int'(pre_due[3]), 1);
    retry(3'd4, 3, 0);
    slot(3'd0, 0, 0, 0);
    slot(3'd0, 0, 0, 0);
    summary();
  end

endmodule